// File: doc/BRIEF.md
# Flash status and protection sequencer

This block keeps the status byte of a serial flash memory and decides whether each decoded command may go ahead. The command engine runs on the serial clock. It sends a command code, a target byte address and a data byte, and flips a single toggle line to commit them. The toggle is brought into the system clock domain through a flop chain, and each flip produces one response pulse. The pulse carries an accept or reject verdict, and the status byte is updated in the same cycle.

The block checks the write-enable latch and the two block-protect bits. It also checks a write-protect pin, which has effect only when status bit 7 is set. It supports a low-power standby mode that locks out modification. An accepted program, erase or status write starts a self-timed busy interval. The length of that interval is a parameter counted in system clocks. The block holds no array storage.

Top module: `flash_guard`

## Requirements
- R1: After synchronous reset, status reads 0x00, `sleep_o` is 0 and `resp_valid` is 0.
- R2: Each flip of `cmd_tgl` gives exactly one `resp_valid` pulse. Command codes are 1 set-latch, 2 clear-latch, 3 status-read, 4 status-write, 5 program, 6 page erase, 7 sector erase, 8 bulk erase, 9 standby, 10 wake. Any other code is rejected.
- R3: When idle and awake, set-latch sets status bit 1 and clear-latch clears it. Both are accepted.
- R4: Status layout is: bit 7 pin-enable, bits 6..4 always 0, bits 3..2 protect level, bit 1 write-enable latch, bit 0 busy. An accepted status-write copies data bits 7, 3 and 2 into the register.
- R5: A status-write is refused when `wp_n` is 0 and bit 7 is 1. It is allowed with `wp_n` at 0 when bit 7 is 0. As a result, bit 7 cannot be cleared while the pin is low.
- R6: The protect level is bits 3..2. Level 00 protects nothing. Level 01 protects 0x30000–0x3FFFF, level 10 protects 0x20000–0x3FFFF, and level 11 protects everything. A program, page erase or sector erase whose address falls in the protected range is rejected.
- R7: Bulk erase is accepted only when the protect level is 00.
- R8: Status-write, program and erase are rejected unless the latch is set. A rejected command leaves every status bit unchanged.
- R9: While a busy interval runs, bits 1 and 0 both read 1 and only status-read is accepted. The latch is clear once the interval ends.
- R10: Standby is accepted when idle, and `sleep_o` then reads 1. In standby only status-read and wake are accepted. Wake leaves standby.
- R11: Standby and wake are both rejected while a busy interval runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_tgl | input | 1 | Commit toggle from the serial-clock domain |
| cmd_op | input | 4 | Decoded command code |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Status-write data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_ok | output | 1 | Command accepted, valid with resp_valid |
| status_o | output | 8 | Status byte |
| sleep_o | output | 1 | Standby mode active |

## Verification
The bench sends commands with the latch both set and clear, so that latch gating is told apart from protection gating. Each protect level is tried with addresses just below and at its lower boundary, which tells an off-by-one range decode apart from a correct one. The status-write is tried with the pin high, with the pin low and bit 7 set, and with the pin low and bit 7 clear, which separates the pin-enable rule from plain latch gating. Commands issued during a busy interval and during standby show which codes pass through each lock.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_WEN    = 4'd1,
        OP_WDIS   = 4'd2,
        OP_RDST   = 4'd3,
        OP_WRST   = 4'd4,
        OP_PROG   = 4'd5,
        OP_PERASE = 4'd6,
        OP_SERASE = 4'd7,
        OP_BERASE = 4'd8,
        OP_SLEEP  = 4'd9,
        OP_WAKE   = 4'd10
    } op_e;

    typedef struct packed {
        logic       pin_en;
        logic [1:0] level;
        logic       wen;
    } sreg_t;

    function automatic logic [7:0] pack_status(sreg_t s, logic busy);
        return {s.pin_en, 3'b000, s.level, s.wen | busy, busy};
    endfunction

    function automatic logic is_cycle_op(op_e op);
        return op inside {OP_PROG, OP_PERASE, OP_SERASE, OP_BERASE};
    endfunction

endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic sh [STAGES];
    logic seen;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[0] <= 1'b0;
                else     sh[0] <= tgl_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= 1'b0;
                else     sh[g] <= sh[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= sh[STAGES-1];
    end

    assign pulse = sh[STAGES-1] ^ seen;
endmodule

// File: rtl/zone_check.sv
module zone_check
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  op_e               op,
    input  logic [1:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    logic [1:0] sector;
    logic       in_zone;

    assign sector = addr[ADDR_W-1 -: 2];

    always_comb begin
        unique case (level)
            2'b00:   in_zone = 1'b0;
            2'b01:   in_zone = (sector == 2'b11);
            2'b10:   in_zone = sector[1];
            default: in_zone = 1'b1;
        endcase
        blocked = (op == OP_BERASE) ? (level != 2'b00) : in_zone;
    end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (start)     cnt <= len;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && len != '0) |=> busy);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYC    = 40,
    parameter int PERASE_CYC  = 45,
    parameter int SERASE_CYC  = 50,
    parameter int BERASE_CYC  = 60,
    parameter int WRST_CYC    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_tgl,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [7:0]        status_o,
    output logic              sleep_o
);
    op_e              op;
    logic             pulse, busy, done, blocked;
    logic             ok, start, nx_sleep, sleeping;
    logic [CNT_W-1:0] len;
    sreg_t            sr, nx;
    logic             spare_unused;

    assign op           = op_e'(cmd_op);
    assign spare_unused = ^{cmd_data[6:4], cmd_data[1:0]};

    toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .tgl_in(cmd_tgl), .pulse(pulse));

    zone_check #(.ADDR_W(ADDR_W)) u_zone (
        .op(op), .level(sr.level), .addr(cmd_addr), .blocked(blocked));

    busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .len(len),
        .busy(busy), .done(done));

    always_comb begin
        ok       = 1'b0;
        start    = 1'b0;
        len      = '0;
        nx       = sr;
        nx_sleep = sleeping;
        if (pulse) begin
            if (busy) begin
                ok = (op == OP_RDST);
            end else if (sleeping) begin
                if (op == OP_RDST) ok = 1'b1;
                else if (op == OP_WAKE) begin
                    ok       = 1'b1;
                    nx_sleep = 1'b0;
                end
            end else begin
                unique case (op)
                    OP_RDST, OP_WAKE: ok = 1'b1;
                    OP_WEN:  begin ok = 1'b1; nx.wen = 1'b1; end
                    OP_WDIS: begin ok = 1'b1; nx.wen = 1'b0; end
                    OP_SLEEP: begin ok = 1'b1; nx_sleep = 1'b1; end
                    OP_WRST: begin
                        if (sr.wen && (wp_n || !sr.pin_en)) begin
                            ok        = 1'b1;
                            nx.pin_en = cmd_data[7];
                            nx.level  = cmd_data[3:2];
                            start     = 1'b1;
                            len       = CNT_W'(WRST_CYC);
                        end
                    end
                    OP_PROG, OP_PERASE, OP_SERASE, OP_BERASE: begin
                        if (sr.wen && !blocked) begin
                            ok    = 1'b1;
                            start = 1'b1;
                            unique case (op)
                                OP_PROG:   len = CNT_W'(PROG_CYC);
                                OP_PERASE: len = CNT_W'(PERASE_CYC);
                                OP_SERASE: len = CNT_W'(SERASE_CYC);
                                default:   len = CNT_W'(BERASE_CYC);
                            endcase
                        end
                    end
                    default: ok = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '0;
            sleeping   <= 1'b0;
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
        end else begin
            resp_valid <= pulse;
            resp_ok    <= ok;
            sleeping   <= nx_sleep;
            sr         <= nx;
            if (done) sr.wen <= 1'b0;
        end
    end

    assign status_o = pack_status(sr, busy);
    assign sleep_o  = sleeping;

    // R9
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && busy && op != OP_RDST) |=> !resp_ok);
    // R5
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && sr.pin_en) |=> sr.pin_en);
    // R9
    wen_drop_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !sr.wen);
    // R7
    bulk_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && op == OP_BERASE && sr.level != 2'b00) |=> !resp_ok);
    // R10
    sleep_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && sleeping && !(op inside {OP_RDST, OP_WAKE})) |=> !resp_ok);
    // R8
    cycle_needs_wen_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse && is_cycle_op(op) && !sr.wen) |=> !resp_ok);
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_tgl = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [17:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic        resp_valid, resp_ok, sleep_o;
    logic [7:0]  status_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        bit         ok;
        logic [7:0] st;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    bit       m_wen = 0, m_pin = 0, m_busy = 0, m_sleep = 0;
    bit [1:0] m_lvl = 0;

    always #(CLK_P/2) clk = ~clk;

    flash_guard uut (
        .clk(clk), .rst(rst), .cmd_tgl(cmd_tgl), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .resp_valid(resp_valid), .resp_ok(resp_ok),
        .status_o(status_o), .sleep_o(sleep_o));

    function automatic logic [7:0] model_status();
        return {m_pin, 3'b000, m_lvl, m_wen | m_busy, m_busy};
    endfunction

    function automatic bit in_zone(bit [1:0] lvl, logic [17:0] a);
        case (lvl)
            2'd0: return 1'b0;
            2'd1: return a >= 18'h30000;
            2'd2: return a >= 18'h20000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic predict(input logic [3:0] op, input logic [17:0] a,
                           input logic [7:0] d, output bit ok);
        ok = 0;
        if (m_busy) ok = (op == 4'd3);
        else if (m_sleep) begin
            if (op == 4'd3) ok = 1;
            else if (op == 4'd10) begin ok = 1; m_sleep = 0; end
        end else begin
            case (op)
                4'd1: begin ok = 1; m_wen = 1; end
                4'd2: begin ok = 1; m_wen = 0; end
                4'd3, 4'd10: ok = 1;
                4'd4: if (m_wen && (wp_n || !m_pin)) begin
                    ok = 1; m_pin = d[7]; m_lvl = d[3:2]; m_busy = 1;
                end
                4'd5, 4'd6, 4'd7: if (m_wen && !in_zone(m_lvl, a)) begin
                    ok = 1; m_busy = 1;
                end
                4'd8: if (m_wen && m_lvl == 2'd0) begin ok = 1; m_busy = 1; end
                4'd9: begin ok = 1; m_sleep = 1; end
                default: ok = 0;
            endcase
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [17:0] a,
                        input logic [7:0] d, input string tag);
        exp_t e;
        bit   ok;
        predict(op, a, d, ok);
        e.ok = ok; e.st = model_status(); e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_tgl = ~cmd_tgl;
        for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++; mismatched++;
            $display("FAIL R2 %s: actual=no response expected=one response", tag);
            exp_q.delete();
        end
    endtask

    task automatic settle();
        repeat (100) @(negedge clk);
        if (m_busy) begin m_busy = 0; m_wen = 0; end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R2 unexpected response: actual=ok%0b/%h expected=none",
                         resp_ok, status_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (resp_ok !== e.ok || status_o !== e.st) begin
                    mismatched++;
                    $display("FAIL %s: actual=ok%0b/%h expected=ok%0b/%h",
                             e.tag, resp_ok, status_o, e.ok, e.st);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        compared++;
        if (status_o !== 8'h00) begin
            mismatched++;
            $display("FAIL R1 status: actual=%h expected=00", status_o);
        end
        check1("R1 sleep_o", sleep_o, 1'b0);
        check1("R1 resp_valid", resp_valid, 1'b0);

        send(4'd3, 18'h0, 8'h0, "R2 status read");
        send(4'd0, 18'h0, 8'h0, "R2 code 0 rejected");
        send(4'd15, 18'h0, 8'h0, "R2 code 15 rejected");
        send(4'd5, 18'h00100, 8'h0, "R8 program without latch");
        send(4'd1, 18'h0, 8'h0, "R3 set latch");
        send(4'd2, 18'h0, 8'h0, "R3 clear latch");
        send(4'd1, 18'h0, 8'h0, "R3 set latch again");

        send(4'd5, 18'h00100, 8'h0, "R9 program starts cycle");
        send(4'd1, 18'h0, 8'h0, "R9 set latch while busy");
        send(4'd3, 18'h0, 8'h0, "R9 status read while busy");
        send(4'd9, 18'h0, 8'h0, "R11 standby while busy");
        settle();
        send(4'd3, 18'h0, 8'h0, "R9 latch clear after cycle");

        send(4'd1, 18'h0, 8'h0, "R4 latch");
        send(4'd4, 18'h0, 8'hFC, "R4 status write bits 6..4 dropped");
        settle();
        send(4'd3, 18'h0, 8'h0, "R4 status after write");

        wp_n = 1'b0;
        send(4'd1, 18'h0, 8'h0, "R5 latch");
        send(4'd4, 18'h0, 8'h00, "R5 pin low bit7 set refused");
        send(4'd3, 18'h0, 8'h0, "R8 refused keeps latch");
        wp_n = 1'b1;
        send(4'd4, 18'h0, 8'h84, "R5 pin high allowed");
        settle();

        send(4'd1, 18'h0, 8'h0, "R6 latch");
        send(4'd5, 18'h30000, 8'h0, "R6 level 01 program at 30000");
        send(4'd7, 18'h3FFFF, 8'h0, "R6 level 01 sector erase top");
        send(4'd8, 18'h0, 8'h0, "R7 bulk erase refused level 01");
        send(4'd5, 18'h2FFFF, 8'h0, "R6 level 01 program at 2FFFF");
        settle();

        send(4'd1, 18'h0, 8'h0, "R4 latch");
        send(4'd4, 18'h0, 8'h08, "R4 set level 10");
        settle();
        send(4'd1, 18'h0, 8'h0, "R6 latch");
        send(4'd6, 18'h20000, 8'h0, "R6 level 10 page erase at 20000");
        send(4'd6, 18'h1FFFF, 8'h0, "R6 level 10 page erase at 1FFFF");
        settle();

        wp_n = 1'b0;
        send(4'd1, 18'h0, 8'h0, "R5 latch");
        send(4'd4, 18'h0, 8'h00, "R5 pin low bit7 clear allowed");
        settle();
        send(4'd1, 18'h0, 8'h0, "R7 latch");
        send(4'd8, 18'h0, 8'h0, "R7 bulk erase level 00");
        send(4'd10, 18'h0, 8'h0, "R11 wake while busy");
        settle();
        wp_n = 1'b1;

        send(4'd9, 18'h0, 8'h0, "R10 enter standby");
        check1("R10 sleep_o set", sleep_o, 1'b1);
        send(4'd1, 18'h0, 8'h0, "R10 latch refused in standby");
        send(4'd5, 18'h00000, 8'h0, "R10 program refused in standby");
        send(4'd3, 18'h0, 8'h0, "R10 status read in standby");
        send(4'd10, 18'h0, 8'h0, "R10 wake");
        check1("R10 sleep_o clear", sleep_o, 1'b0);
        send(4'd1, 18'h0, 8'h0, "R10 latch after wake");

        send(4'd4, 18'h0, 8'h0C, "R4 set level 11");
        settle();
        send(4'd1, 18'h0, 8'h0, "R6 latch");
        send(4'd5, 18'h00000, 8'h0, "R6 level 11 program at 0");

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule